// File: doc/BRIEF.md
# Two-Channel APB Interval Timer

A memory-mapped down-counting interval timer that sits behind an APB slave port. Each channel holds a control word, a reload value and a live 32-bit counter. A channel only counts while its enable bit is set. When it is already at zero, the next count tick loads it from its reload value and latches an expiry flag. Software can also overwrite the live counter at any time.

A channel can count on every bus clock or on rising edges of its own external tick input. That input is asynchronous and is synchronized inside the block. The per-channel enable, interrupt-enable and status bits share one layout: channel c uses bit 4*c of each shared register. Status bits are cleared by writing ones. A single level interrupt merges the enabled status bits.

Mode codes for split 16-bit and 8-bit operation are kept and read back, but every channel counts as a full 32-bit timer. The port has no wait states: reads are combinational during the access phase, and writes take effect on the clock edge that ends the access phase.

Top module: `apb_interval_timer`

## Requirements
- R1: After reset every writable register, every counter, every status bit and `irq_o` are zero.
- R2: Channel c places its control word at 0x20+0x10*c, its reload value at 0x24+0x10*c and its counter at 0x28+0x10*c. The control word keeps bits 3:0 and reads zero above them. Reload and counter read back what was written.
- R3: In bus-clock mode (control bit 3 = 1), an enabled channel whose counter is non-zero decrements by one on every clock edge.
- R4: An enabled channel at zero loads its reload value on the next count tick and sets its status bit (bit 4*c of 0x18) on that same edge.
- R5: Channel c counts only while bit 4*c of the enable register at 0x1C is 1. While it is 0 the counter holds. Setting the bit again resumes counting from the held value.
- R6: In external mode (control bit 3 = 0), the external tick passes through two flops. Each rising edge advances the counter once, on the third clock edge after the input is first sampled high. A level held high advances it only once.
- R7: A bus write to the counter becomes the current count. It takes precedence over a count tick on the same edge.
- R8: Writing 1 to a bit of the status register at 0x18 clears it. Writing 0 leaves it unchanged.
- R9: `irq_o` is high exactly when some status bit is set and the interrupt enable bit at the same position of 0x14 is set.
- R10: The register at 0x00 reads the constant `ID_VALUE`. The register at 0x10 reads the channel count. Writes to both are ignored.
- R11: Mode codes 2 and 3 in control bits 2:0 are stored and read back, but the channel counts as a 32-bit timer.
- R12: In the enable, interrupt-enable and status registers, only bits 4*c for existing channels are implemented. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock and count clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| ext_tick | input | NUM_CH | Asynchronous external tick, one per channel |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench checks the counter value after a known number of edges across an enable/disable pair. It also overwrites the counter while the channel is running. A design that let the tick win over the write, or that counted one edge too many or too few, would read back a value off by one or more.

The expiry case is checked by loading 3 and reloading from 50. A design that set status one edge late, or decremented instead of reloading at zero, would read 48 or a wrapped value. The external tick is held high across several clock edges; a level-triggered design would count those edges instead of one per pulse.

Mode code 2 is tested with a count that crosses a 16-bit boundary. A design that truly split the counter would not land on 0xFFFF.

// File: rtl/itm_pkg.sv
package itm_pkg;
  localparam int DW = 32;
  localparam logic [7:0] OFF_ID   = 8'h00;
  localparam logic [7:0] OFF_CFG  = 8'h10;
  localparam logic [7:0] OFF_IEN  = 8'h14;
  localparam logic [7:0] OFF_STA  = 8'h18;
  localparam logic [7:0] OFF_CHEN = 8'h1C;

  // bit position used by channel c in every shared register
  function automatic int chan_bit(input int c);
    return 4 * c;
  endfunction

  function automatic logic [7:0] ctrl_off(input int c);
    return 8'(8'h20 + 16 * c);
  endfunction

  function automatic logic [7:0] reload_off(input int c);
    return 8'(8'h24 + 16 * c);
  endfunction

  function automatic logic [7:0] count_off(input int c);
    return 8'(8'h28 + 16 * c);
  endfunction

  // value after one count tick
  function automatic logic [DW-1:0] next_count(input logic [DW-1:0] cur,
                                               input logic [DW-1:0] rld);
    return (cur == '0) ? rld : cur - 1'b1;
  endfunction
endpackage

// File: rtl/itm_tick_sync.sv
module itm_tick_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/itm_channel.sv
module itm_channel import itm_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          ctrl_wr_i,
  input  logic          reload_wr_i,
  input  logic          cnt_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ext_tick_i,
  output logic [3:0]    ctrl_o,
  output logic [DW-1:0] reload_o,
  output logic [DW-1:0] count_o,
  output logic          expire_o
);
  logic ext_rise;
  logic tick;
  logic step;

  itm_tick_sync sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(ext_tick_i),
    .rise_o (ext_rise)
  );

  // bit 3 picks bus clock; bits 2:0 (mode) are stored only
  assign tick     = ctrl_o[3] ? 1'b1 : ext_rise;
  assign step     = tick & en_i & ~cnt_wr_i;
  assign expire_o = step & (count_o == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o   <= '0;
      reload_o <= '0;
      count_o  <= '0;
    end else begin
      if (ctrl_wr_i)   ctrl_o   <= wdata_i[3:0];
      if (reload_wr_i) reload_o <= wdata_i;
      if (cnt_wr_i)    count_o  <= wdata_i;
      else if (step)   count_o  <= next_count(count_o, reload_o);
    end
  end

  assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count_o != '0) |=> count_o == $past(count_o) - 1'b1);
  assert_reload_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !reload_wr_i) |=> count_o == $past(reload_o));
  assert_hold_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !cnt_wr_i) |=> $stable(count_o));
  assert_direct_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_i |=> count_o == $past(wdata_i));
endmodule

// File: rtl/apb_interval_timer.sv
module apb_interval_timer import itm_pkg::*; #(
  parameter int          NUM_CH   = 2,
  parameter logic [31:0] ID_VALUE = 32'h0A11_0100
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [7:0]        paddr,
  input  logic [DW-1:0]     pwdata,
  output logic [DW-1:0]     prdata,
  input  logic [NUM_CH-1:0] ext_tick,
  output logic              irq_o
);
  logic              acc_wr;
  logic [NUM_CH-1:0] wr_bits;
  logic [NUM_CH-1:0] en_q, ie_q, sta_q;
  logic [NUM_CH-1:0] expire, clr_hit;
  logic [3:0]        ctrl_a   [NUM_CH];
  logic [DW-1:0]     reload_a [NUM_CH];
  logic [DW-1:0]     count_a  [NUM_CH];

  assign acc_wr = psel & penable & pwrite;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) wr_bits[c] = pwdata[chan_bit(c)];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    itm_channel chan_i (
      .clk        (pclk),
      .rst_n      (presetn),
      .en_i       (en_q[c]),
      .ctrl_wr_i  (acc_wr && paddr == ctrl_off(c)),
      .reload_wr_i(acc_wr && paddr == reload_off(c)),
      .cnt_wr_i   (acc_wr && paddr == count_off(c)),
      .wdata_i    (pwdata),
      .ext_tick_i (ext_tick[c]),
      .ctrl_o     (ctrl_a[c]),
      .reload_o   (reload_a[c]),
      .count_o    (count_a[c]),
      .expire_o   (expire[c])
    );

    assign clr_hit[c] = acc_wr && paddr == OFF_STA && wr_bits[c];

    // expiry outranks a clear on the same edge
    always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn)        sta_q[c] <= 1'b0;
      else if (expire[c])  sta_q[c] <= 1'b1;
      else if (clr_hit[c]) sta_q[c] <= 1'b0;
    end

    assert_status_on_expire_R4: assert property (@(posedge pclk) disable iff (!presetn)
      expire[c] |=> sta_q[c]);
    assert_w1c_clears_R8: assert property (@(posedge pclk) disable iff (!presetn)
      (clr_hit[c] && !expire[c]) |=> !sta_q[c]);
    assert_status_hold_R8: assert property (@(posedge pclk) disable iff (!presetn)
      (!clr_hit[c] && !expire[c]) |=> $stable(sta_q[c]));
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      en_q <= '0;
      ie_q <= '0;
    end else if (acc_wr) begin
      if (paddr == OFF_CHEN) en_q <= wr_bits;
      if (paddr == OFF_IEN)  ie_q <= wr_bits;
    end
  end

  assign irq_o = |(sta_q & ie_q);

  function automatic logic [DW-1:0] spread(input logic [NUM_CH-1:0] v);
    logic [DW-1:0] r;
    r = '0;
    for (int c = 0; c < NUM_CH; c++) r[chan_bit(c)] = v[c];
    return r;
  endfunction

  always_comb begin
    prdata = '0;
    case (paddr)
      OFF_ID:   prdata = ID_VALUE;
      OFF_CFG:  prdata = DW'(NUM_CH);
      OFF_IEN:  prdata = spread(ie_q);
      OFF_STA:  prdata = spread(sta_q);
      OFF_CHEN: prdata = spread(en_q);
      default: begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (paddr == ctrl_off(c))   prdata = {28'd0, ctrl_a[c]};
          if (paddr == reload_off(c)) prdata = reload_a[c];
          if (paddr == count_off(c))  prdata = count_a[c];
        end
      end
    endcase
  end

  assert_irq_needs_enable_R9: assert property (@(posedge pclk) disable iff (!presetn)
    irq_o |-> (ie_q != '0 && sta_q != '0));
endmodule

// File: tb/apb_interval_timer_tb.sv
module apb_interval_timer_tb_top;
  localparam logic [31:0] ID_EXP = 32'h0A11_0100;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [1:0]  ext_tick = '0;
  logic        irq;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  apb_interval_timer dut_i (
    .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .ext_tick(ext_tick), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk);
    penable = 1;
    #1 d = prdata;
    psel = 0; penable = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 chen", 8'h1C, 0);
    rd_chk("R1 sta", 8'h18, 0);
    rd_chk("R1 count0", 8'h28, 0);
    rd_chk("R1 ctrl1", 8'h30, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_id_cfg;
    wr(8'h00, 32'hDEAD_BEEF);
    wr(8'h10, 32'h0000_00FF);
    rd_chk("R10 id", 8'h00, ID_EXP);
    rd_chk("R10 cfg", 8'h10, 2);
  endtask

  task automatic t_map;
    wr(8'h30, 32'hFFFF_FFF5);
    rd_chk("R2 ctrl1 bits", 8'h30, 32'h5);
    wr(8'h34, 32'h1234_5678);
    rd_chk("R2 reload1", 8'h34, 32'h1234_5678);
    wr(8'h38, 32'h0BAD_F00D);
    rd_chk("R2 count1", 8'h38, 32'h0BAD_F00D);
    wr(8'h14, 32'hFFFF_FFFF);
    rd_chk("R12 ien bits", 8'h14, 32'h11);
    wr(8'h14, 0);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h1C, 0);
    rd_chk("R12 chen bits", 8'h1C, 0);
  endtask

  task automatic t_count;
    wr(8'h20, 32'h9);
    wr(8'h28, 100);
    wr(8'h1C, 32'h1);
    repeat (10) @(negedge clk);
    wr(8'h1C, 0);
    rd_chk("R3 decrement per clock", 8'h28, 87);
    repeat (5) @(negedge clk);
    rd_chk("R5 hold while off", 8'h28, 87);
    wr(8'h24, 7);
    wr(8'h1C, 32'h1);
    wr(8'h1C, 0);
    rd_chk("R5 resume", 8'h28, 84);
  endtask

  task automatic t_expire;
    wr(8'h28, 3);
    wr(8'h24, 50);
    wr(8'h14, 32'h1);
    wr(8'h1C, 32'h1);
    repeat (2) @(negedge clk);
    wr(8'h1C, 0);
    rd_chk("R4 reload from 50", 8'h28, 49);
    rd_chk("R4 status set", 8'h18, 32'h1);
    chk("R9 irq on", {31'd0, irq}, 1);
    wr(8'h14, 0);
    chk("R9 irq masked", {31'd0, irq}, 0);
    wr(8'h14, 32'h1);
    chk("R9 irq back", {31'd0, irq}, 1);
    wr(8'h18, 0);
    rd_chk("R8 write zero keeps", 8'h18, 32'h1);
    wr(8'h18, 32'h1);
    rd_chk("R8 write one clears", 8'h18, 0);
    chk("R9 irq off", {31'd0, irq}, 0);
  endtask

  task automatic t_direct;
    wr(8'h1C, 32'h1);
    repeat (4) @(negedge clk);
    wr(8'h28, 500);
    wr(8'h1C, 0);
    rd_chk("R7 direct load", 8'h28, 497);
  endtask

  task automatic t_mode;
    wr(8'h20, 32'hA);
    rd_chk("R11 mode stored", 8'h20, 32'hA);
    wr(8'h28, 32'h0001_0002);
    wr(8'h1C, 32'h1);
    wr(8'h1C, 0);
    rd_chk("R11 full width", 8'h28, 32'h0000_FFFF);
  endtask

  task automatic t_ext;
    wr(8'h30, 32'h1);
    wr(8'h38, 10);
    wr(8'h1C, 32'h10);
    repeat (5) @(negedge clk);
    rd_chk("R6 no tick no count", 8'h38, 10);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); ext_tick[1] = 1'b1;
      repeat (4) @(negedge clk);
      ext_tick[1] = 1'b0;
      repeat (4) @(negedge clk);
    end
    rd_chk("R6 one step per edge", 8'h38, 7);
    wr(8'h1C, 0);
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_id_cfg;
    t_map;
    t_count;
    t_expire;
    t_direct;
    t_mode;
    t_ext;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule